// File: doc/BRIEF.md
# Multiplexed Bidirectional GPIO Port

This block is an 8-bit general-purpose I/O port whose pins can be handed to other on-chip functions. Software reaches it through three registers on a small register bus: a direction register, an output latch, and a pin-level view. When no other function claims a pin, the pin drives the latch bit or floats, as its direction bit says.

A per-pin override multiplexer can take a pin away from the plain port. Three functions can do this. The external address/data bus claims all pins. A serial peripheral can claim the pins in a fixed window (bits 4 to 6 by default). The parallel slave port claims all pins and drives the latch contents onto them. The multiplexer is purely combinational, so a change of an override enable moves pin direction in the same cycle. Each claiming function also receives the raw pin levels on its own input bus while it holds the pins.

The pad outputs are plain drive and enable vectors. The register bus is a fixed-latency control interface with no back-pressure: a write lands on the next clock edge and a read is answered combinationally in the same cycle.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset every direction bit is 1, every latch bit is 0, and every pin output enable is 0.
- R2: A write to address 0 or address 1 stores the write data in the output latch at the next rising edge. A write to address 3 changes neither the latch nor the direction register.
- R3: A write to address 2 stores the direction register. With no override active, a pin with direction bit 0 has output enable 1 and drives its latch bit, and a pin with direction bit 1 has output enable 0.
- R4: With read enable high, address 1 returns the latch (not the pin level), address 2 returns the direction register, and address 3 returns 0. With read enable low the read data is 0.
- R5: With read enable high, address 0 returns the pin inputs through a two-stage synchronizer, whatever the pin directions. A pin change is visible after the second rising edge and not after the first.
- R6: While the external bus enable is 1, the direction register is ignored on all pins. Outside a read phase every pin has output enable 1 and drives the bus address/data output. In a read phase every output enable is 0 and the bus input bus carries the pin levels. Otherwise that bus input is 0.
- R7: While the parallel slave port is enabled and the external bus is not, each pin outside an active serial override has its output enable equal to the port's drive request and drives its latch bit. The port's input bus carries the pin levels, and it is 0 whenever the port is not the active owner.
- R8: A serial override bit set on a pin inside the serial window (bits 4 to 6) makes that pin's enable and data follow the serial peripheral's enable and data. This beats the parallel slave port and the plain port, but not the external bus. Serial override bits outside the window have no effect. The serial input bus carries the pin levels inside the window and 0 elsewhere.
- R9: Pin output enables and drive values respond to override inputs in the same cycle, with no register in the path.
- R10: A pin whose output enable is 0 has drive value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 2 | Register address: 0 pin view, 1 latch, 2 direction |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read enable |
| reg_rdata | output | 8 | Register read data |
| ext_bus_en | input | 1 | External address/data bus owns the pins |
| ext_rd_phase | input | 1 | External bus is sampling data from the pins |
| ext_ad_out | input | 8 | External bus address/data to drive |
| ext_ad_in | output | 8 | Pin levels routed to the external bus |
| psp_en | input | 1 | Parallel slave port mode |
| psp_oe | input | 1 | Parallel slave port requests the pins to drive the latch |
| psp_din | output | 8 | Pin levels routed to the parallel slave port |
| ser_en | input | 8 | Per-pin serial override request |
| ser_out | input | 8 | Per-pin serial drive value |
| ser_oe | input | 8 | Per-pin serial output enable |
| ser_din | output | 8 | Pin levels routed to the serial peripheral (window bits only) |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad drive values |
| pin_oe | output | 8 | Pad output enables |

## Verification
The assertions assume the override inputs are steady around each rising clock edge and that the pad input comes from the bench rather than looping back from the pad outputs. The stimulus keeps to this by changing every input only at the falling edge. Register writes are presented for one full cycle and checked at the following falling edge. The priority cases are applied with no clock edge between setting the inputs and sampling the pins, which exercises the same-cycle path.

// File: rtl/gpio_mux_pkg.sv
`timescale 1ns/1ps
package gpio_mux_pkg;
  typedef enum logic [1:0] {
    ADDR_PIN   = 2'd0,
    ADDR_LATCH = 2'd1,
    ADDR_DIR   = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_PLAIN = 2'd0,
    SRC_PSP   = 2'd1,
    SRC_SER   = 2'd2,
    SRC_EXT   = 2'd3
  } pin_src_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
  import gpio_mux_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] rdata
);
  reg_addr_e addr_e;
  logic      latch_we;
  logic      dir_we;

  assign addr_e   = reg_addr_e'(addr);
  assign latch_we = wr && (addr_e == ADDR_PIN || addr_e == ADDR_LATCH);
  assign dir_we   = wr && (addr_e == ADDR_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '1;
    end else begin
      if (latch_we) latch_q <= wdata;
      if (dir_we)   dir_q   <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr_e)
        ADDR_PIN:   rdata = pin_sync;
        ADDR_LATCH: rdata = latch_q;
        ADDR_DIR:   rdata = dir_q;
        ADDR_NONE:  rdata = '0;
        default:    rdata = '0;
      endcase
    end
  end

  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_q == '1 && latch_q == '0)); // R1
  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr != 2'd2 && addr != 2'd3) |=> latch_q == $past(wdata)); // R2
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd2) |=> dir_q == $past(wdata)); // R3
  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd3) |=> ($stable(latch_q) && $stable(dir_q))); // R2
endmodule

// File: rtl/gpio_pin_mux.sv
`timescale 1ns/1ps
module gpio_pin_mux
  import gpio_mux_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int SER_LO = 4,
  parameter int SER_HI = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic             ext_bus_en,
  input  logic             ext_rd_phase,
  input  logic [WIDTH-1:0] ext_ad_out,
  input  logic             psp_en,
  input  logic             psp_oe,
  input  logic [WIDTH-1:0] ser_en,
  input  logic [WIDTH-1:0] ser_out,
  input  logic [WIDTH-1:0] ser_oe,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] ext_ad_in,
  output logic [WIDTH-1:0] psp_din,
  output logic [WIDTH-1:0] ser_din
);
  pin_src_e src [WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    localparam bit IN_WIN = (i >= SER_LO) && (i <= SER_HI);
    logic ser_claim;
    logic oe_raw;
    logic out_raw;

    if (IN_WIN) begin : g_ser
      assign ser_claim  = ser_en[i];
      assign ser_din[i] = pin_in[i];
    end else begin : g_noser
      assign ser_claim  = 1'b0;
      assign ser_din[i] = 1'b0;
    end

    always_comb begin
      if (ext_bus_en)     src[i] = SRC_EXT;
      else if (ser_claim) src[i] = SRC_SER;
      else if (psp_en)    src[i] = SRC_PSP;
      else                src[i] = SRC_PLAIN;
    end

    always_comb begin
      unique case (src[i])
        SRC_EXT: begin
          oe_raw  = !ext_rd_phase;
          out_raw = ext_ad_out[i];
        end
        SRC_SER: begin
          oe_raw  = ser_oe[i];
          out_raw = ser_out[i];
        end
        SRC_PSP: begin
          oe_raw  = psp_oe;
          out_raw = latch_q[i];
        end
        default: begin
          oe_raw  = !dir_q[i];
          out_raw = latch_q[i];
        end
      endcase
    end

    assign pin_oe[i]  = oe_raw;
    assign pin_out[i] = oe_raw & out_raw;
  end

  assign ext_ad_in = (ext_bus_en && ext_rd_phase) ? pin_in : '0;
  assign psp_din   = (psp_en && !ext_bus_en) ? pin_in : '0;

  AST_EXT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_bus_en && !ext_rd_phase) |-> (pin_oe == '1 && pin_out == ext_ad_out)); // R6
  AST_EXT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_bus_en && ext_rd_phase) |-> (pin_oe == '0 && ext_ad_in == pin_in)); // R6
  AST_PSP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_bus_en && psp_en && psp_oe && ser_en == '0) |-> pin_out == latch_q); // R7
  AST_PLAIN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_bus_en && !psp_en && ser_en == '0) |-> pin_oe == ~dir_q); // R3
endmodule

// File: rtl/gpio_mux_port.sv
`timescale 1ns/1ps
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SER_LO      = 4,
  parameter int SER_HI      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [WIDTH-1:0] reg_wdata,
  input  logic             reg_rd,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic             ext_bus_en,
  input  logic             ext_rd_phase,
  input  logic [WIDTH-1:0] ext_ad_out,
  output logic [WIDTH-1:0] ext_ad_in,
  input  logic             psp_en,
  input  logic             psp_oe,
  output logic [WIDTH-1:0] psp_din,
  input  logic [WIDTH-1:0] ser_en,
  input  logic [WIDTH-1:0] ser_out,
  input  logic [WIDTH-1:0] ser_oe,
  output logic [WIDTH-1:0] ser_din,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pin_sync;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (pin_in),
    .q (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (reg_addr),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .rd       (reg_rd),
    .pin_sync (pin_sync),
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .rdata    (reg_rdata)
  );

  gpio_pin_mux #(.WIDTH(WIDTH), .SER_LO(SER_LO), .SER_HI(SER_HI)) u_mux (
    .clk          (clk),
    .rst_n        (rst_n),
    .latch_q      (latch_q),
    .dir_q        (dir_q),
    .ext_bus_en   (ext_bus_en),
    .ext_rd_phase (ext_rd_phase),
    .ext_ad_out   (ext_ad_out),
    .psp_en       (psp_en),
    .psp_oe       (psp_oe),
    .ser_en       (ser_en),
    .ser_out      (ser_out),
    .ser_oe       (ser_oe),
    .pin_in       (pin_in),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .ext_ad_in    (ext_ad_in),
    .psp_din      (psp_din),
    .ser_din      (ser_din)
  );

  AST_NO_FLOAT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R10
  AST_RESET_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !ext_bus_en && !psp_en && ser_en == '0) |-> pin_oe == '0); // R1
endmodule

// File: tb/gpio_mux_port_tb.sv
`timescale 1ns/1ps
module gpio_mux_port_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       ext_bus_en, ext_rd_phase, psp_en, psp_oe;
  logic [7:0] ext_ad_out, ext_ad_in, psp_din;
  logic [7:0] ser_en, ser_out, ser_oe, ser_din;
  logic [7:0] pin_in, pin_out, pin_oe;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_mux_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .ext_bus_en(ext_bus_en), .ext_rd_phase(ext_rd_phase),
    .ext_ad_out(ext_ad_out), .ext_ad_in(ext_ad_in),
    .psp_en(psp_en), .psp_oe(psp_oe), .psp_din(psp_din),
    .ser_en(ser_en), .ser_out(ser_out), .ser_oe(ser_oe), .ser_din(ser_din),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {ext_en, rd_phase, psp_en, psp_oe, ser_en, ser_out, ser_oe, ext_ad, exp_oe, exp_out}
  // latch = A5, direction = CF while walking the table
  localparam int NV = 9;
  localparam logic [51:0] VEC [NV] = '{
    {4'b0000, 8'h00, 8'h00, 8'h00, 8'h00, 8'h30, 8'h20},  // R3 plain
    {4'b1000, 8'h00, 8'h00, 8'h00, 8'h3C, 8'hFF, 8'h3C},  // R6 bus drive
    {4'b1100, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h00},  // R6 read phase
    {4'b0011, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hA5},  // R7 psp drive
    {4'b0010, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},  // R10 psp released
    {4'b0000, 8'h70, 8'h50, 8'h70, 8'h00, 8'h70, 8'h50},  // R8 serial over plain
    {4'b0011, 8'h70, 8'hFF, 8'h20, 8'h00, 8'hAF, 8'hA5},  // R8 serial over psp
    {4'b0000, 8'h8F, 8'hFF, 8'hFF, 8'h00, 8'h30, 8'h20},  // R8 outside window
    {4'b1010, 8'h70, 8'h00, 8'h70, 8'hC3, 8'hFF, 8'hC3}   // R6 bus over all
  };
  string vtag [NV] = '{"R3", "R6", "R6", "R7", "R10", "R8", "R8", "R8", "R6"};

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic clear_ovr();
    ext_bus_en = 0; ext_rd_phase = 0; ext_ad_out = 0;
    psp_en = 0; psp_oe = 0; ser_en = 0; ser_out = 0; ser_oe = 0;
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 0; reg_addr = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    pin_in = 8'h00;
    clear_ovr();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", pin_oe, 8'h00);
    rd_reg(2'd2, r); chk("R1 dir", r, 8'hFF);
    rd_reg(2'd1, r); chk("R1 latch", r, 8'h00);

    // R2 latch via port address and latch address
    wr_reg(2'd0, 8'h3C);
    rd_reg(2'd1, r); chk("R2 addr0", r, 8'h3C);
    wr_reg(2'd1, 8'hA5);
    rd_reg(2'd1, r); chk("R2 addr1", r, 8'hA5);
    chk("R1 still floating", pin_oe, 8'h00);

    // R3 direction
    wr_reg(2'd2, 8'hCF);
    rd_reg(2'd2, r); chk("R3 dir", r, 8'hCF);

    // R2 unmapped write ignored
    wr_reg(2'd3, 8'h11);
    rd_reg(2'd1, r); chk("R2 addr3 latch", r, 8'hA5);
    rd_reg(2'd2, r); chk("R2 addr3 dir", r, 8'hCF);

    // R4 reads
    rd_reg(2'd3, r); chk("R4 addr3", r, 8'h00);
    reg_addr = 2'd1; reg_rd = 1'b0; #1 chk("R4 no rd", reg_rdata, 8'h00);

    // R5 synchronizer latency, pins 4/5 are outputs but read shows pin_in
    @(negedge clk);
    pin_in = 8'h5A;
    @(negedge clk);
    rd_reg(2'd0, r); chk("R5 one edge", r, 8'h00);
    rd_reg(2'd1, r); chk("R4 latch not pin", r, 8'hA5);
    @(negedge clk);
    rd_reg(2'd0, r); chk("R5 two edges", r, 8'h5A);

    // priority table; no clock edge between drive and sample (R9)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ext_bus_en, ext_rd_phase, psp_en, psp_oe} = VEC[i][51:48];
      ser_en = VEC[i][47:40]; ser_out = VEC[i][39:32];
      ser_oe = VEC[i][31:24]; ext_ad_out = VEC[i][23:16];
      #1;
      chk({vtag[i], " R9 oe"}, pin_oe, VEC[i][15:8]);
      chk({vtag[i], " out"}, pin_out, VEC[i][7:0]);
    end

    // routed input buses
    @(negedge clk); clear_ovr();
    ext_bus_en = 1; ext_rd_phase = 1; #1;
    chk("R6 bus in", ext_ad_in, 8'h5A);
    ext_rd_phase = 0; #1;
    chk("R6 bus in idle", ext_ad_in, 8'h00);
    psp_en = 1; #1;
    chk("R7 psp blocked by bus", psp_din, 8'h00);
    ext_bus_en = 0; #1;
    chk("R7 psp in", psp_din, 8'h5A);
    chk("R8 ser in", ser_din, 8'h50);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule